// File: doc/BRIEF.md
# Overlapped Bidirectional Max-Log MAP Output Scheduler

This block runs one frame of max-log MAP soft-output generation with the forward and backward recursions working at the same time. The forward recursion starts at symbol 0 and the backward recursion starts at the last symbol. On every accepted step the block tells the surrounding recursion and branch-metric logic which two symbol indices to present. One is the forward index `t`. The other is the mirrored backward index `W-1-t`. Branch metrics are therefore requested out of natural order, so that both ends of the frame are fed.

During the first half of the frame the block saves the forward state metrics of the low half and the backward state metrics of the high half in a local store. Once the two recursions cross the midpoint, each step pairs a fresh metric vector with the partner vector saved earlier for the same index. Each step then emits two soft outputs, one for each side, each tagged with its symbol index. The outputs are meant to be written into an external output buffer. A one-cycle done pulse marks the last pair. The recursion arithmetic itself is not part of this block.

The trellis is a shift-register trellis with `NS` states. Frame length `W` (a power of two), state count, metric width and output width are parameters.

Top module: `map_overlap_sched`

## Requirements
- R1: After reset, `busy`, `done`, `out0_valid` and `out1_valid` are low and `fwd_idx` is 0.
- R2: A `start` while idle begins a frame. On the k-th accepted step of a frame (`busy` and `step_en` high, k counted from 0), `fwd_idx` equals k and `bwd_idx` equals `W-1-k`.
- R3: Accepted steps with `fwd_idx < W/2` produce no soft output: the valids are low in the following cycle.
- R4: Every accepted step with `fwd_idx >= W/2` raises `out0_valid` and `out1_valid` in the next cycle. In that cycle `out0_idx` holds that step's `fwd_idx` and `out1_idx` holds its `bwd_idx`.
- R5: The soft output for index k is M1 − M0. Mb is the maximum of `alpha[k][s] + gamma[k][s][b] + beta[k][(2s+b) mod NS]` over all states s, with bit label b. `alpha[s]` and `beta[s]` occupy bits `[s*MW +: MW]`. `gamma[s][b]` occupies bits `[(2s+b)*MW +: MW]`. All metrics are signed two's complement.
- R6: A soft output whose value lies outside the signed `LW`-bit range is clamped to `2^(LW-1)-1` or `-2^(LW-1)`.
- R7: A cycle with `busy` high and `step_en` low leaves both indices unchanged and produces no soft output.
- R8: `done` is high for exactly one cycle, namely the cycle that carries the last output pair. In that same cycle `busy` is low.
- R9: `start` while `busy` is ignored: the indices keep their values and the frame continues.
- R10: `step_en` while idle is ignored: no output appears, and a later frame still begins at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a frame when idle |
| step_en | input | 1 | Presented metrics are valid; the step advances |
| busy | output | 1 | Frame in progress |
| fwd_idx | output | $clog2(W) | Symbol index the forward side must present |
| bwd_idx | output | $clog2(W) | Symbol index the backward side must present |
| alpha_in | input | NS*MW | Forward state metrics at `fwd_idx` |
| gamma_f | input | 2*NS*MW | Branch metrics at `fwd_idx` |
| beta_in | input | NS*MW | Backward state metrics at `bwd_idx` |
| gamma_b | input | 2*NS*MW | Branch metrics at `bwd_idx` |
| out0_valid | output | 1 | Forward-side soft output valid |
| out0_idx | output | $clog2(W) | Index of the forward-side soft output |
| out0_llr | output | LW | Forward-side soft output (signed) |
| out1_valid | output | 1 | Backward-side soft output valid |
| out1_idx | output | $clog2(W) | Index of the backward-side soft output |
| out1_llr | output | LW | Backward-side soft output (signed) |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bound checker checks the schedule on every cycle:
- the index advances by one on each accepted step;
- stalls and starts during a frame leave the index unchanged;
- nothing is emitted in the first half of the frame;
- output indices fall on the correct side of the midpoint;
- the done pulse is a single cycle.

The numeric content of each soft output cannot be seen by a property. Neither can the pairing of a fresh vector with the partner saved half a frame earlier, or the clamping. Only the bench's frames show these. The bench runs frames with small metrics, which never clamp, and with large metrics, which clamp often, and compares every emitted value against a model built from R5 and R6.

// File: rtl/map_overlap_sched.sv
module map_overlap_sched #(
  parameter int W  = 128,
  parameter int NS = 4,
  parameter int MW = 9,
  parameter int LW = 8,
  localparam int IW = $clog2(W),
  localparam int HALF = W / 2,
  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        step_en,
  output logic                        busy,
  output logic [IW-1:0]               fwd_idx,
  output logic [IW-1:0]               bwd_idx,
  input  logic [NS*MW-1:0]            alpha_in,
  input  logic [2*NS*MW-1:0]          gamma_f,
  input  logic [NS*MW-1:0]            beta_in,
  input  logic [2*NS*MW-1:0]          gamma_b,
  output logic                        out0_valid,
  output logic [IW-1:0]               out0_idx,
  output logic signed [LW-1:0]        out0_llr,
  output logic                        out1_valid,
  output logic [IW-1:0]               out1_idx,
  output logic signed [LW-1:0]        out1_llr,
  output logic                        done
);
  localparam int SW = MW + 2;
  localparam int DW = MW + 3;
  localparam logic signed [DW-1:0] LMAX = DW'((2 ** (LW - 1)) - 1);
  localparam logic signed [DW-1:0] LMIN = DW'(-(2 ** (LW - 1)));

  function automatic logic signed [LW-1:0] combine(
    input logic [NS*MW-1:0]   a,
    input logic [2*NS*MW-1:0] g,
    input logic [NS*MW-1:0]   b
  );
    logic signed [SW-1:0] m0, m1, t;
    logic signed [DW-1:0] d;
    m0 = {1'b1, {(SW-1){1'b0}}};
    m1 = {1'b1, {(SW-1){1'b0}}};
    for (int s = 0; s < NS; s++) begin
      for (int u = 0; u < 2; u++) begin
        t = SW'(signed'(a[s*MW +: MW]))
          + SW'(signed'(g[(2*s+u)*MW +: MW]))
          + SW'(signed'(b[((2*s+u) % NS)*MW +: MW]));
        if (u == 1) begin
          if (t > m1) m1 = t;
        end else if (t > m0) begin
          m0 = t;
        end
      end
    end
    d = DW'(m1) - DW'(m0);
    if (d > LMAX)      return LMAX[LW-1:0];
    else if (d < LMIN) return LMIN[LW-1:0];
    else               return d[LW-1:0];
  endfunction

  logic          busy_q, ov_q, done_q;
  logic [IW-1:0] cnt;
  logic [NS*MW-1:0] a_mem [HALF];
  logic [NS*MW-1:0] b_mem [HALF];

  wire          adv    = busy_q & step_en;
  wire          second = (cnt >= IW'(HALF));
  wire [HW-1:0] lo     = cnt[HW-1:0];
  wire [HW-1:0] mir    = ~cnt[HW-1:0];

  assign busy       = busy_q;
  assign fwd_idx    = cnt;
  assign bwd_idx    = IW'(W - 1) - cnt;
  assign out0_valid = ov_q;
  assign out1_valid = ov_q;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (adv && !second) begin
      a_mem[lo]  <= alpha_in;
      b_mem[mir] <= beta_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt    <= '0;
      ov_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ov_q   <= adv && second;
      done_q <= adv && (cnt == IW'(W - 1));
      if (!busy_q && start) begin
        busy_q <= 1'b1;
        cnt    <= '0;
      end else if (adv) begin
        cnt <= cnt + 1'b1;
        if (cnt == IW'(W - 1)) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out0_idx <= '0;
      out1_idx <= '0;
      out0_llr <= '0;
      out1_llr <= '0;
    end else if (adv && second) begin
      out0_idx <= fwd_idx;
      out1_idx <= bwd_idx;
      out0_llr <= combine(alpha_in, gamma_f, b_mem[lo]);
      out1_llr <= combine(a_mem[mir], gamma_b, beta_in);
    end
  end
endmodule

// File: rtl/map_overlap_sched_chk.sv
module map_overlap_sched_chk #(
  parameter int W = 128,
  localparam int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          step_en,
  input logic          busy,
  input logic [IW-1:0] fwd_idx,
  input logic          done,
  input logic          out0_valid,
  input logic [IW-1:0] out0_idx,
  input logic [IW-1:0] out1_idx
);
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_en && fwd_idx != IW'(W - 1)) |=> (busy && fwd_idx == $past(fwd_idx) + 1'b1));

  a_r3_first_half_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step_en && fwd_idx < IW'(W / 2)) |=> !out0_valid);

  a_r4_index_sides: assert property (@(posedge clk) disable iff (!rst_n)
    out0_valid |-> (out0_idx >= IW'(W / 2) && out1_idx < IW'(W / 2)));

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_en) |=> (!out0_valid && $stable(fwd_idx)));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && out0_valid));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !step_en) |=> (busy && $stable(fwd_idx)));

  a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
endmodule

bind map_overlap_sched map_overlap_sched_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .step_en(step_en), .busy(busy),
  .fwd_idx(fwd_idx), .done(done), .out0_valid(out0_valid),
  .out0_idx(out0_idx), .out1_idx(out1_idx)
);

// File: tb/map_overlap_sched_test.sv
module map_overlap_sched_test;
  localparam int W = 128, NS = 4, MW = 9, LW = 8;
  localparam int IW = $clog2(W);
  localparam int HALF = W / 2;
  localparam int NF = 5;
  localparam int SEED  [NF] = '{3, 17, 101, 7, 55};
  localparam int AMP   [NF] = '{16, 8, 256, 200, 12};
  localparam int STALL [NF] = '{8'h00, 8'h25, 8'h00, 8'h81, 8'h10};
  localparam int POKE  [NF] = '{0, 1, 0, 0, 1};

  logic clk = 0, rst_n = 0, start = 0, step_en = 0;
  logic busy, done, out0_valid, out1_valid;
  logic [IW-1:0] fwd_idx, bwd_idx, out0_idx, out1_idx;
  logic [NS*MW-1:0] alpha_in = '0, beta_in = '0;
  logic [2*NS*MW-1:0] gamma_f = '0, gamma_b = '0;
  logic signed [LW-1:0] out0_llr, out1_llr;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  map_overlap_sched #(.W(W), .NS(NS), .MW(MW), .LW(LW)) uut (
    .clk, .rst_n, .start, .step_en, .busy, .fwd_idx, .bwd_idx,
    .alpha_in, .gamma_f, .beta_in, .gamma_b,
    .out0_valid, .out0_idx, .out0_llr, .out1_valid, .out1_idx, .out1_llr, .done);

  function automatic int gen(int seed, int amp, int kind, int idx, int elem);
    int h = seed * 1103 + kind * 7919 + idx * 131 + elem * 29 + idx * elem * 17;
    h = h ^ (h >> 3);
    return (h % (2 * amp)) - amp;
  endfunction

  function automatic int model(int seed, int amp, int k);
    int m0 = -100000, m1 = -100000;
    for (int s = 0; s < NS; s++)
      for (int u = 0; u < 2; u++) begin
        int t = gen(seed, amp, 0, k, s) + gen(seed, amp, 1, k, 2*s+u)
              + gen(seed, amp, 2, k, (2*s+u) % NS);
        if (u == 1 && t > m1) m1 = t;
        if (u == 0 && t > m0) m0 = t;
      end
    return m1 - m0;
  endfunction

  function automatic int clamp(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int seed, int amp);
    for (int s = 0; s < NS; s++) begin
      alpha_in[s*MW +: MW] = MW'(gen(seed, amp, 0, int'(fwd_idx), s));
      beta_in[s*MW +: MW]  = MW'(gen(seed, amp, 2, int'(bwd_idx), s));
    end
    for (int e = 0; e < 2*NS; e++) begin
      gamma_f[e*MW +: MW] = MW'(gen(seed, amp, 1, int'(fwd_idx), e));
      gamma_b[e*MW +: MW] = MW'(gen(seed, amp, 1, int'(bwd_idx), e));
    end
  endtask

  task automatic run_frame(int seed, int amp, int stall, int poke);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1 && fwd_idx == 0, "R2 frame begins at 0", int'(fwd_idx), 0);
    for (int i = 0; i < W; i++) begin
      int kf, kb, e0, e1;
      if (stall[i % 8]) begin
        step_en = 0;
        @(negedge clk);
        chk(!out0_valid && fwd_idx == IW'(i), "R7 stall", int'(fwd_idx), i);
      end
      if (poke != 0 && i == 5) begin
        start = 1; step_en = 0;
        @(negedge clk) start = 0;
        chk(busy && fwd_idx == IW'(i), "R9 start ignored", int'(fwd_idx), i);
      end
      kf = int'(fwd_idx); kb = int'(bwd_idx);
      chk(kf == i && kb == W-1-i, "R2 indices", kf, i);
      drive(seed, amp);
      step_en = 1;
      @(negedge clk) step_en = 0;
      if (i < HALF) begin
        chk(!out0_valid && !out1_valid, "R3 quiet first half", int'(out0_valid), 0);
      end else begin
        e0 = model(seed, amp, kf); e1 = model(seed, amp, kb);
        chk(out0_valid && out1_valid, "R4 pair valid", int'(out0_valid), 1);
        chk(int'(out0_idx) == kf, "R4 out0 index", int'(out0_idx), kf);
        chk(int'(out1_idx) == kb, "R4 out1 index", int'(out1_idx), kb);
        chk(int'(out0_llr) == clamp(e0), (clamp(e0) != e0) ? "R6 out0 clamp" : "R5 out0 value",
            int'(out0_llr), clamp(e0));
        chk(int'(out1_llr) == clamp(e1), (clamp(e1) != e1) ? "R6 out1 clamp" : "R5 out1 value",
            int'(out1_llr), clamp(e1));
      end
      if (i == W - 1) chk(done && !busy, "R8 done with last pair", int'(done), 1);
      else            chk(!done, "R8 no early done", int'(done), 0);
    end
    @(negedge clk);
    chk(!done && !busy && !out0_valid, "R8 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    chk(!busy && !done && !out0_valid && !out1_valid && fwd_idx == 0, "R1 reset state",
        int'(busy), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !out0_valid && fwd_idx == 0, "R1 after release", int'(busy), 0);
    step_en = 1;
    repeat (3) @(negedge clk) begin
      chk(!busy && !out0_valid && !out1_valid, "R10 idle step ignored", int'(out0_valid), 0);
    end
    step_en = 0;
    for (int f = 0; f < NF; f++) run_frame(SEED[f], AMP[f], STALL[f], POKE[f]);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule